// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This block holds several independent 16-bit timer channels behind one small register port. Each channel counts up at a rate picked from the input clock or one of three prescaled rates. It compares the count against four compare registers (A to D). On a match it can clear itself, drive two output pins, and raise a sticky flag. The flag can in turn assert that channel's interrupt line. A channel can also be set to clear whenever another channel clears itself on a compare match. This keeps a group of channels in phase.

Software programs a channel while it is stopped. It then sets the channel's run bit in one start register that all channels share. On a flag interrupt, software reads the status register and writes 0 to the flag bit it wants to acknowledge. Each channel occupies a 16-byte window at `channel * 16`. Inside that window the control byte is at 0, the pin-control byte at 2, interrupt enables at 4, status at 5, the counter halfword at 6, and compares A, B, C and D at 8, 10, 12 and 14. The start register sits at address 0xF0. Bytes 1, 3 and 7 read as zero.

Top module: `tmr_unit`

## Requirements
- R1: After reset every counter reads 0, every compare register reads 0xFFFF, status, enables and the start register read 0, and all interrupt and pin outputs are low.
- R2: Bit i of the start register (address 0xF0, read back as written) runs channel i. A stopped channel holds its counter, and its prescaler phase returns to zero, so counting always begins from the same phase.
- R3: Control bits 2:0 pick the count rate: 0 counts every cycle, and 1, 2 and 3 divide by 4, 16 and 64; codes 4 to 7 never count. Control bits 4:3 pick the edge of the divided clock: 0 rising, 1 falling, 2 or 3 both (twice the rate). With code 0 the edge setting has no effect.
- R4: On each count tick without a clear the counter adds one and wraps from 0xFFFF to 0.
- R5: A match occurs when the counter equals a compare register on a count tick, and it sets that compare's status bit (A bit 0, B bit 1, C bit 2, D bit 3). Control bits 7:5 pick the clear source: 0 none, 1 compare A, 2 compare B, 5 compare C, 6 compare D. On a match of the selected compare the counter becomes 0 instead of incrementing, which gives a period of compare value plus one ticks.
- R6: With clear source 3 a running channel clears to 0 in any cycle in which another channel clears itself on a compare match.
- R7: A bus write to the counter or a compare register takes effect at once and overrides an increment or clear in the same cycle.
- R8: Pin-control low nibble drives pin A on compare A, high nibble drives pin B on compare B. Writing a code of 1, 2 or 3 sets the pin low, and writing 5, 6 or 7 sets it high. On a later match, codes ending in 1 clear the pin, 2 set it and 3 toggle it. Codes 0 and 4 leave the pin unchanged.
- R9: A status bit clears only when 0 is written to it after a status read that saw it set. Bits written 1 do not change, a 0 written without such a read has no effect, and a match in the same cycle wins over the clear.
- R10: A channel's interrupt output is the OR over A to D of each status bit ANDed with the enable bit at the same position of the enable register.
- R11: All registers of every channel read back at their documented offsets, and each channel's registers are independent of the other channels' registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, marks status reads |
| bus_wdata | input | CW | Write data, byte registers use bits 7:0 |
| bus_rdata | output | CW | Read data for bus_addr, combinational |
| tmr_irq | output | NCH | Interrupt line per channel |
| tmr_out_a | output | NCH | Compare A output pin per channel |
| tmr_out_b | output | NCH | Compare B output pin per channel |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume each access is a single one-cycle strobe and that a status read and a status write are never issued in the same cycle. The clear and step properties further assume that the prescaler setting changes only while a channel is stopped. The stimulus meets these assumptions. Every write and read is issued by one task that raises one strobe for exactly one clock. Control bytes are rewritten only after the start register has stopped the channel, and bus inputs change only on the falling clock edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

   localparam int NCMP = 4;

   localparam logic [3:0] OFF_CTRL = 4'h0;
   localparam logic [3:0] OFF_IOC  = 4'h2;
   localparam logic [3:0] OFF_IE   = 4'h4;
   localparam logic [3:0] OFF_STS  = 4'h5;
   localparam logic [3:0] OFF_CNT  = 4'h6;
   localparam logic [3:0] OFF_CMP  = 4'h8;

   localparam logic [2:0] CLR_SYNC = 3'd3;

   typedef struct packed {
      logic [2:0] clr;
      logic [1:0] edg;
      logic [2:0] psc;
   } ctrl_t;

   function automatic logic [NCMP-1:0] clr_onehot(input logic [2:0] code);
      case (code)
         3'd1:    return 4'b0001;
         3'd2:    return 4'b0010;
         3'd5:    return 4'b0100;
         3'd6:    return 4'b1000;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
   parameter int STEP  = 2,
   parameter int NSTEP = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] psc,
   input  logic [1:0] edg,
   output logic       tick
);
   localparam int PW = STEP * (NSTEP - 1);

   if (STEP < 1 || NSTEP < 2 || NSTEP > 8) begin : g_bad_cfg
      $error("tmr_prescaler: STEP must be >= 1 and NSTEP within 2..8");
   end

   logic [PW-1:0]    pre;
   logic [NSTEP-1:0] cand;
   logic             sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre <= '0;
      else if (!run) pre <= '0;
      else           pre <= pre + 1'b1;
   end

   assign cand[0] = 1'b1;

   for (genvar d = 1; d < NSTEP; d++) begin : g_div
      localparam int K = d * STEP - 1;
      logic low;
      if (K == 0) begin : g_k0
         assign low = 1'b1;
      end else begin : g_kn
         assign low = &pre[K-1:0];
      end
      assign cand[d] = (edg == 2'd0) ? (low & ~pre[K]) :
                       (edg == 2'd1) ? (low &  pre[K]) : low;
   end

   always_comb begin
      sel = 1'b0;
      for (int i = 0; i < NSTEP; i++)
         if (psc == 3'(i)) sel = cand[i];
   end

   assign tick = run & sel;

   // R3: a divided rate never yields ticks on two consecutive edges
   a_r3_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick && psc != 3'd0 |=> !tick || psc != $past(psc));

endmodule

// File: rtl/tmr_pin.sv
`timescale 1ns/1ps
module tmr_pin (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [3:0] new_code,
   input  logic [3:0] code,
   input  logic       match,
   output logic       pin
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin <= 1'b0;
      end else if (cfg_we) begin
         if (!new_code[3] && new_code[1:0] != 2'b00) pin <= new_code[2];
      end else if (match && !code[3]) begin
         case (code[1:0])
            2'd1:    pin <= 1'b0;
            2'd2:    pin <= 1'b1;
            2'd3:    pin <= ~pin;
            default: pin <= pin;
         endcase
      end
   end

   // R8: retain codes leave the pin alone
   a_r8_retain: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we && code[1:0] == 2'b00 |=> pin == $past(pin));

   // R8: a set action on match drives the pin high
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we && match && !code[3] && code[1:0] == 2'd2 |=> pin);

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CW     = 16,
   parameter int PSTEP  = 2,
   parameter int PNSTEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [3:0]    off,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] rdata,
   input  logic          sync_in,
   output logic          clr_evt,
   output logic          out_a,
   output logic          out_b,
   output logic          irq
);
   localparam int NPIN = 2;

   ctrl_t                      ctrl;
   logic [7:0]                 ioc;
   logic [NCMP-1:0]            ie, flag, seen;
   logic [CW-1:0]              cnt;
   logic [NCMP-1:0][CW-1:0]    cmp;

   logic                       tick;
   logic [NCMP-1:0]            match, cmp_we, flag_clr, flag_n, seen_n;
   logic                       ctrl_we, ioc_we, ie_we, sts_we, cnt_we, sts_rd;
   logic                       own_clr, sync_hit;
   logic [NPIN-1:0]            pins;

   tmr_prescaler #(.STEP(PSTEP), .NSTEP(PNSTEP)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .psc  (ctrl.psc),
      .edg  (ctrl.edg),
      .tick (tick)
   );

   assign ctrl_we = wr_en && off == OFF_CTRL;
   assign ioc_we  = wr_en && off == OFF_IOC;
   assign ie_we   = wr_en && off == OFF_IE;
   assign sts_we  = wr_en && off == OFF_STS;
   assign cnt_we  = wr_en && off == OFF_CNT;
   assign sts_rd  = rd_en && off == OFF_STS;

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      assign cmp_we[i] = wr_en && off == OFF_CMP + 4'(2 * i);
      assign match[i]  = tick && cnt == cmp[i];
   end

   assign own_clr  = |(clr_onehot(ctrl.clr) & match);
   assign sync_hit = run && ctrl.clr == CLR_SYNC && sync_in;
   assign clr_evt  = own_clr && !cnt_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         ioc  <= '0;
         ie   <= '0;
         cmp  <= '1;
      end else begin
         if (ctrl_we) ctrl <= ctrl_t'(wdata[7:0]);
         if (ioc_we)  ioc  <= wdata[7:0];
         if (ie_we)   ie   <= wdata[NCMP-1:0];
         for (int i = 0; i < NCMP; i++)
            if (cmp_we[i]) cmp[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (cnt_we)              cnt <= wdata;
      else if (sync_hit || own_clr) cnt <= '0;
      else if (tick)                cnt <= cnt + 1'b1;
   end

   assign flag_clr = {NCMP{sts_we}} & ~wdata[NCMP-1:0] & seen;
   assign flag_n   = match | (flag & ~flag_clr);
   assign seen_n   = flag_n & ~flag_clr & (seen | ({NCMP{sts_rd}} & flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= '0;
         seen <= '0;
      end else begin
         flag <= flag_n;
         seen <= seen_n;
      end
   end

   assign irq = |(flag & ie);

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      tmr_pin u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_we  (ioc_we),
         .new_code(wdata[4*p +: 4]),
         .code    (ioc[4*p +: 4]),
         .match   (match[p]),
         .pin     (pins[p])
      );
   end
   assign out_a = pins[0];
   assign out_b = pins[1];

   always_comb begin
      rdata = '0;
      case (off)
         OFF_CTRL: rdata = CW'(ctrl);
         OFF_IOC:  rdata = CW'(ioc);
         OFF_IE:   rdata = CW'(ie);
         OFF_STS:  rdata = CW'(flag);
         OFF_CNT:  rdata = cnt;
         default: begin
            for (int i = 0; i < NCMP; i++)
               if (off == OFF_CMP + 4'(2 * i)) rdata = cmp[i];
         end
      endcase
   end

   // R2: a stopped channel keeps its count unless written
   a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !cnt_we |=> cnt == $past(cnt));

   // R4: a plain tick advances the count by one
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !cnt_we && !own_clr && !sync_hit |=> cnt == $past(cnt) + 1'b1);

   // R5: a match of the selected clear source returns the count to zero
   a_r5_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      own_clr && !cnt_we |=> cnt == '0);

   // R7: a bus write to the counter wins over counting
   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt == $past(wdata));

   for (genvar i = 0; i < NCMP; i++) begin : g_flag_chk
      // R5: a match always leaves its status bit set
      a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
         match[i] |=> flag[i]);
      // R9: a flag not yet read cannot be cleared
      a_r9_unread_holds: assert property (@(posedge clk) disable iff (!rst_n)
         flag[i] && !seen[i] |=> flag[i]);
   end

endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int          NCH        = 3,
   parameter int          CW         = 16,
   parameter int          AW         = 8,
   parameter int unsigned START_ADDR = 'hF0,
   parameter int          PSTEP      = 2,
   parameter int          PNSTEP     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [CW-1:0] bus_wdata,
   output logic [CW-1:0] bus_rdata,
   output logic [NCH-1:0] tmr_irq,
   output logic [NCH-1:0] tmr_out_a,
   output logic [NCH-1:0] tmr_out_b
);
   localparam int CHB = AW - 4;

   if (NCH < 1 || NCH > 8 || CW < 8 || CW > 16 || AW < 5 ||
       (START_ADDR >> 4) < NCH || START_ADDR >= (1 << AW)) begin : g_bad_cfg
      $error("tmr_unit: parameter set out of range");
   end

   logic [NCH-1:0]          run, clr_evt, ch_sel;
   logic [NCH-1:0][CW-1:0]  ch_rdata;
   logic                    start_hit;

   assign start_hit = bus_addr == AW'(START_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run <= '0;
      else if (bus_wr && start_hit) run <= bus_wdata[NCH-1:0];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ch_sel[c] = bus_addr[AW-1:4] == CHB'(c);

      tmr_channel #(.CW(CW), .PSTEP(PSTEP), .PNSTEP(PNSTEP)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run[c]),
         .wr_en  (bus_wr && ch_sel[c]),
         .rd_en  (bus_rd && ch_sel[c]),
         .off    (bus_addr[3:0]),
         .wdata  (bus_wdata),
         .rdata  (ch_rdata[c]),
         .sync_in(|(clr_evt & ~(NCH'(1) << c))),
         .clr_evt(clr_evt[c]),
         .out_a  (tmr_out_a[c]),
         .out_b  (tmr_out_b[c]),
         .irq    (tmr_irq[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (start_hit) bus_rdata = CW'(run);
      else
         for (int c = 0; c < NCH; c++)
            if (ch_sel[c]) bus_rdata = ch_rdata[c];
   end

   // R2: the start register takes the written run bits
   a_r2_start_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && start_hit |=> run == $past(bus_wdata[NCH-1:0]));

   // R2: without a start write the run bits stay put
   a_r2_start_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && start_hit) |=> $stable(run));

endmodule

// File: tb/tmr_unit_test.sv
`timescale 1ns/1ps
module tmr_unit_test;
   localparam int NCH = 3;
   localparam int CW  = 16;
   localparam logic [7:0] START = 8'hF0;
   localparam int NVEC = 11;

   // {control byte, running edges, expected count}
   localparam logic [31:0] VEC [NVEC] = '{
      {8'h00, 12'd20,  12'd20},
      {8'h08, 12'd20,  12'd20},
      {8'h01, 12'd62,  12'd16},
      {8'h09, 12'd62,  12'd15},
      {8'h11, 12'd62,  12'd31},
      {8'h02, 12'd62,  12'd4},
      {8'h0A, 12'd62,  12'd3},
      {8'h12, 12'd62,  12'd7},
      {8'h03, 12'd100, 12'd2},
      {8'h0B, 12'd100, 12'd1},
      {8'h04, 12'd50,  12'd0}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [7:0]     addr = '0;
   logic           wr = 1'b0;
   logic           rd = 1'b0;
   logic [CW-1:0]  wdata = '0;
   logic [CW-1:0]  rdata;
   logic [NCH-1:0] irq, oa, ob;

   int total = 0;
   int failed = 0;
   bit done = 1'b0;

   tmr_unit #(.NCH(NCH), .CW(CW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (addr),
      .bus_wr   (wr),
      .bus_rd   (rd),
      .bus_wdata(wdata),
      .bus_rdata(rdata),
      .tmr_irq  (irq),
      .tmr_out_a(oa),
      .tmr_out_b(ob)
   );

   always #2.5 clk = ~clk;

   function automatic logic [7:0] ra(input int ch, input int off);
      return 8'(ch * 16 + off);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [15:0] v);
      addr = a; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic run_edges(input logic [2:0] mask, input int m);
      wr_reg(START, 16'(mask));
      repeat (m - 1) @(negedge clk);
      wr_reg(START, 16'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; failed++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, v2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(ra(0, 6), v);  check("R1 counter", v, 0);
      rd_reg(ra(1, 8), v);  check("R1 compare A", v, 16'hFFFF);
      rd_reg(ra(2, 14), v); check("R1 compare D", v, 16'hFFFF);
      rd_reg(ra(0, 5), v);  check("R1 status", v, 0);
      rd_reg(START, v);     check("R1 start reg", v, 0);
      check("R1 outputs", {irq, oa, ob}, 0);

      // R3 rate and edge table
      for (int i = 0; i < NVEC; i++) begin
         wr_reg(ra(0, 0), 16'(VEC[i][31:24]));
         wr_reg(ra(0, 6), 16'h0);
         run_edges(3'b001, int'(VEC[i][23:12]));
         rd_reg(ra(0, 6), v);
         check($sformatf("R3 ctrl=%h", VEC[i][31:24]), v, 32'(VEC[i][11:0]));
      end

      // R2 stopped channel holds
      rd_reg(ra(0, 6), v);
      repeat (10) @(negedge clk);
      rd_reg(ra(0, 6), v2);
      check("R2 hold while stopped", v2, v);

      // R5 clear on compare A, period cmp+1
      wr_reg(ra(0, 0), 16'h20);
      wr_reg(ra(0, 8), 16'd4);
      wr_reg(ra(0, 6), 16'h0);
      wr_reg(ra(0, 4), 16'h1);
      run_edges(3'b001, 13);
      rd_reg(ra(0, 6), v);
      check("R5 clear on A count", v, 3);
      check("R10 irq with enable", irq[0], 1);

      // R10 enable masks the interrupt
      wr_reg(ra(0, 4), 16'h0);
      check("R10 irq masked", irq[0], 0);
      wr_reg(ra(0, 4), 16'h1);
      check("R10 irq unmasked", irq[0], 1);

      // R9 read then write zero
      wr_reg(ra(0, 5), 16'h0);
      check("R9 unread clear ignored", irq[0], 1);
      rd_reg(ra(0, 5), v);
      check("R5 status flag A", v, 16'h1);
      wr_reg(ra(0, 5), 16'hFF);
      check("R9 write one keeps", irq[0], 1);
      wr_reg(ra(0, 5), 16'h0E);
      check("R9 flag cleared irq", irq[0], 0);
      rd_reg(ra(0, 5), v);
      check("R9 status after clear", v, 0);

      // R8 pin actions
      wr_reg(ra(0, 2), 16'h53);
      check("R8 initial levels a", oa[0], 0);
      check("R8 initial levels b", ob[0], 1);
      wr_reg(ra(0, 10), 16'd2);
      wr_reg(ra(0, 6), 16'h0);
      run_edges(3'b001, 7);
      check("R8 toggle on A", oa[0], 1);
      check("R8 clear on B", ob[0], 0);
      rd_reg(ra(0, 6), v);
      check("R5 count after 7", v, 2);
      wr_reg(ra(0, 2), 16'h21);
      check("R8 code1 init low", oa[0], 0);
      wr_reg(ra(0, 6), 16'h0);
      run_edges(3'b001, 3);
      check("R8 set on B", ob[0], 1);
      check("R8 A untouched", oa[0], 0);
      wr_reg(ra(0, 2), 16'h00);
      run_edges(3'b001, 5);
      check("R8 retain code a", oa[0], 0);
      check("R8 retain code b", ob[0], 1);
      wr_reg(ra(0, 2), 16'h06);
      check("R8 code6 init high", oa[0], 1);

      // R7 write beats increment
      wr_reg(ra(0, 0), 16'h00);
      wr_reg(ra(0, 6), 16'h0);
      wr_reg(START, 16'h1);
      wr_reg(ra(0, 6), 16'h100);
      wr_reg(START, 16'h0);
      rd_reg(ra(0, 6), v);
      check("R7 write wins", v, 16'h101);

      // R4 wrap
      wr_reg(ra(0, 6), 16'hFFFE);
      run_edges(3'b001, 3);
      rd_reg(ra(0, 6), v);
      check("R4 wrap", v, 16'h1);

      // R6 synchronous clear
      wr_reg(ra(0, 0), 16'h20);
      wr_reg(ra(0, 6), 16'h0);
      wr_reg(ra(1, 0), 16'h60);
      wr_reg(ra(1, 6), 16'd10);
      wr_reg(ra(2, 0), 16'h00);
      wr_reg(ra(2, 6), 16'd10);
      run_edges(3'b111, 7);
      rd_reg(ra(0, 6), v);  check("R6 master count", v, 2);
      rd_reg(ra(1, 6), v);  check("R6 synced slave", v, 2);
      rd_reg(ra(2, 6), v);  check("R6 free channel", v, 17);

      // R5 clear on compare C, R10 bit 2 enable
      wr_reg(ra(2, 0), 16'hA0);
      wr_reg(ra(2, 12), 16'd2);
      wr_reg(ra(2, 6), 16'h0);
      wr_reg(ra(2, 4), 16'h4);
      run_edges(3'b100, 7);
      rd_reg(ra(2, 6), v);  check("R5 clear on C count", v, 1);
      rd_reg(ra(2, 5), v);  check("R5 flag C", v, 16'h4);
      check("R10 irq channel 2", irq, 3'b101);

      // R11 readback and isolation
      wr_reg(ra(2, 14), 16'h1234);
      wr_reg(ra(1, 14), 16'hBEEF);
      rd_reg(ra(2, 14), v); check("R11 ch2 compare D", v, 16'h1234);
      rd_reg(ra(1, 14), v); check("R11 ch1 compare D", v, 16'hBEEF);
      rd_reg(ra(2, 0), v);  check("R11 ch2 control", v, 16'hA0);
      rd_reg(ra(2, 1), v);  check("R11 unused byte", v, 0);
      wr_reg(START, 16'h5);
      rd_reg(START, v);     check("R2 start readback", v, 5);
      wr_reg(START, 16'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule